// File: doc/BRIEF.md
# Accumulator Instruction Decode and Execute

This block is the accumulator slice of a processor that uses 16-bit instruction words. It decodes the load, logic, complement, negate, normalise, shift, rotate and store instructions of the accumulator group. It then applies each one to a 32-bit accumulator and a carry flag. Operands come from a 16-bit data-memory word that has already been fetched, from an 8-bit immediate inside the instruction, or from a second 16-bit immediate word. Loads can scale the operand by a left shift. The shift count is taken from the opcode, fixed at sixteen, or read from a 4-bit count held outside the block.

An instruction is presented with `instr_valid` together with its memory operand. A single-word instruction updates the architectural state at the next rising edge. A two-word (long-immediate) instruction raises `busy` for one cycle. The following edge then samples `imm_word` and completes the operation. The block ignores anything on `instr` during that cycle. Store instructions leave the accumulator untouched: they pulse `store_valid` with a shifted half of the accumulator on `store_data`.

Top module: `acc_exec`

## Requirements
- R1: While `rst_n` is low, the accumulator, carry, `busy`, `store_valid` and `norm_done` all clear to zero at each rising edge.
- R2: Memory-operand load `0001 ssss xxxx xxxx` writes the operand, sign-extended to 32 bits and shifted left by `ssss`, into the accumulator. Word `0110 1010 xxxx xxxx` writes the operand into bits 31:16 and clears bits 15:0.
- R3: Word `0110 1001 xxxx xxxx` loads the memory operand into bits 15:0 and clears bits 31:16. Word `1011 1001 bbbb bbbb` loads the 8-bit value `bbbb bbbb` into bits 7:0 and clears the rest.
- R4: Word `0110 1011 xxxx xxxx` loads the sign-extended memory operand shifted left by the 4-bit `treg_cnt` input.
- R5: Word `0110 1110 xxxx xxxx` ANDs the accumulator with the zero-extended memory operand. Word `0110 1101 xxxx xxxx` ORs it in the same way.
- R6: A two-word instruction accepted at edge k raises `busy` for exactly the cycle after edge k and leaves the accumulator unchanged at edge k. Its result comes from `imm_word` sampled at edge k+1. `instr` and `instr_valid` are ignored at edge k+1.
- R7: Long-immediate forms: `1011 1111 1011 ssss` is AND, `1011 1111 1100 ssss` is OR, with the zero-extended immediate shifted left by `ssss`. `1011 1110 1000 0001` and `1011 1110 1000 0010` are AND and OR with a shift of 16. `1011 1111 1000 ssss` loads the sign-extended immediate shifted left by `ssss`.
- R8: `1011 1110 0000 0001` replaces the accumulator with its bitwise complement. `1011 1110 0000 0010` replaces it with its two's-complement negation.
- R9: `1011 1110 0000 1001` shifts the accumulator left one bit, with old bit 31 going to carry. `1011 1110 0000 1010` shifts it right arithmetically one bit, with old bit 0 going to carry.
- R10: `1011 1110 0000 1100` rotates left through carry (carry enters bit 0, old bit 31 goes to carry). `1011 1110 0000 1101` rotates right through carry (carry enters bit 31, old bit 0 goes to carry).
- R11: `1001 h sss xxxx xxxx` leaves the accumulator and carry unchanged. It pulses `store_valid` for one cycle with `store_data` equal to bits 31:16 (h=1) or 15:0 (h=0) of the accumulator shifted left by `sss`.
- R12: `1010 0000 xxxx xxxx` shifts the accumulator left one bit and clears `norm_done` when the accumulator is nonzero and bits 31 and 30 are equal. Otherwise it leaves the accumulator unchanged and sets `norm_done`. `norm_done` holds its value between normalise instructions.
- R13: An unrecognised word, or a cycle with no instruction and no pending immediate, changes nothing and gives no store pulse.
- R14: Carry changes only under the shift and rotate instructions of R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction word is presented on `instr` |
| instr | input | 16 | Instruction word |
| imm_word | input | 16 | Second word of a long-immediate instruction, sampled while `busy` |
| mem_data | input | 16 | Data-memory operand for the presented instruction |
| treg_cnt | input | 4 | Left-shift count for the register-scaled load |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry flag |
| store_data | output | 16 | Shifted accumulator half from the last store |
| store_valid | output | 1 | One-cycle strobe marking new `store_data` |
| busy | output | 1 | Second word of a long-immediate instruction expected this cycle |
| norm_done | output | 1 | Last normalise step found the accumulator already normalised |

## Verification
The bound assertions watch the sequencing rules on every cycle. `busy` lasts one cycle and only follows an accepted first word. A first word and a store never disturb the accumulator. Idle cycles hold all state. Carry moves only after a real single-word instruction. The arithmetic content can only be shown by the bench's scenarios, which compare every result against a reference model. That content covers sign versus zero extension, the three sources of shift count, rotate-through-carry ordering, store shifting, the normalise stopping conditions, rejection of stray encodings, and the discarding of a word presented while the immediate is being taken.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator execute slice.
// Assumes 16-bit instruction words and a 32-bit accumulator.
package acc_pkg;

    localparam int INSN_W  = 16;          // instruction and data word width
    localparam int ACC_W   = 2 * INSN_W;  // accumulator width
    localparam int SHAMT_W = 5;           // operand shift count, 0..16
    localparam int STSH_W  = 3;           // store shift count, 0..7
    localparam int IMM8_W  = 8;           // short immediate width

    // Operation classes after decode; long-immediate variants share a class
    typedef enum logic [3:0] {
        OP_NOP,
        OP_LOAD,
        OP_LOAD_LO,
        OP_LOAD_SHORT,
        OP_LOAD_TREG,
        OP_AND,
        OP_OR,
        OP_CMPL,
        OP_NEG,
        OP_SHL,
        OP_SHR,
        OP_ROTL,
        OP_ROTR,
        OP_STORE_HI,
        OP_STORE_LO,
        OP_NORM
    } acc_op_e;

    // Decoded instruction
    typedef struct packed {
        acc_op_e              op;
        logic                 two_word;
        logic [SHAMT_W-1:0]   shamt;
        logic [IMM8_W-1:0]    imm8;
    } acc_dec_t;

endpackage

// File: rtl/acc_decode.sv
// Instruction decoder for the accumulator group.
// Purely combinational; words outside the group decode to OP_NOP.
// Assumes the fixed 16-bit encoding, so the word width is not a parameter.
module acc_decode
    import acc_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output acc_dec_t          dec
);

    // Pattern match the opcode fields into an operation and a shift count
    always_comb begin
        dec          = '0;
        dec.op       = OP_NOP;
        dec.imm8     = instr[IMM8_W-1:0];
        casez (instr)
            16'b0001_????_????_????: begin
                dec.op    = OP_LOAD;
                dec.shamt = {1'b0, instr[11:8]};
            end
            16'b1001_????_????_????: begin
                dec.op    = instr[11] ? OP_STORE_HI : OP_STORE_LO;
                dec.shamt = {2'b00, instr[10:8]};
            end
            16'b0110_1010_????_????: begin
                dec.op    = OP_LOAD;
                dec.shamt = 5'd16;
            end
            16'b0110_1110_????_????: dec.op = OP_AND;
            16'b0110_1101_????_????: dec.op = OP_OR;
            16'b0110_1001_????_????: dec.op = OP_LOAD_LO;
            16'b0110_1011_????_????: dec.op = OP_LOAD_TREG;
            16'b1011_1001_????_????: dec.op = OP_LOAD_SHORT;
            16'b1011_1111_1011_????: begin
                dec.op       = OP_AND;
                dec.two_word = 1'b1;
                dec.shamt    = {1'b0, instr[3:0]};
            end
            16'b1011_1111_1100_????: begin
                dec.op       = OP_OR;
                dec.two_word = 1'b1;
                dec.shamt    = {1'b0, instr[3:0]};
            end
            16'b1011_1111_1000_????: begin
                dec.op       = OP_LOAD;
                dec.two_word = 1'b1;
                dec.shamt    = {1'b0, instr[3:0]};
            end
            16'b1011_1110_1000_0001: begin
                dec.op       = OP_AND;
                dec.two_word = 1'b1;
                dec.shamt    = 5'd16;
            end
            16'b1011_1110_1000_0010: begin
                dec.op       = OP_OR;
                dec.two_word = 1'b1;
                dec.shamt    = 5'd16;
            end
            16'b1011_1110_0000_0001: dec.op = OP_CMPL;
            16'b1011_1110_0000_0010: dec.op = OP_NEG;
            16'b1011_1110_0000_1001: dec.op = OP_SHL;
            16'b1011_1110_0000_1010: dec.op = OP_SHR;
            16'b1011_1110_0000_1100: dec.op = OP_ROTL;
            16'b1011_1110_0000_1101: dec.op = OP_ROTR;
            16'b1010_0000_????_????: dec.op = OP_NORM;
            default:                 dec.op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/acc_lshift.sv
// Logarithmic left shifter: one stage per bit of the count, zero fill.
// Assumes the count never needs to exceed W-1 for a meaningful result.
module acc_lshift #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);

    logic [W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    // Each stage shifts by 2**i when bit i of the count is set
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/acc_alu.sv
// Next-state logic for accumulator, carry, store word and normalise flag.
// Combinational; the caller gates the write enables with its fire strobe.
// Assumes the operand arrives already extended and scaled.
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = INSN_W,
    parameter int SST_W  = STSH_W,
    localparam int A_W   = 2 * WORD_W
) (
    input  acc_op_e           op,
    input  logic [SST_W-1:0]  st_shamt,
    input  logic [IMM8_W-1:0] imm8,
    input  logic [WORD_W-1:0] mem,
    input  logic [A_W-1:0]    opnd,
    input  logic [A_W-1:0]    acc_q,
    input  logic              carry_q,
    output logic [A_W-1:0]    acc_d,
    output logic              acc_we,
    output logic              carry_d,
    output logic              carry_we,
    output logic [WORD_W-1:0] st_d,
    output logic              st_we,
    output logic              nd_d,
    output logic              nd_we
);

    localparam int MSB = A_W - 1;

    logic [A_W-1:0] st_sh;

    // Shifted copy of the accumulator for the store path
    acc_lshift #(.W(A_W), .SH_W(SST_W)) u_st_sh (
        .din  (acc_q),
        .amt  (st_shamt),
        .dout (st_sh)
    );

    // Pick the half that the store instruction names
    always_comb begin
        st_d = (op == OP_STORE_HI) ? st_sh[A_W-1:WORD_W] : st_sh[WORD_W-1:0];
    end

    // Compute the next accumulator, carry and flag values per operation
    always_comb begin
        acc_d    = acc_q;
        acc_we   = 1'b0;
        carry_d  = carry_q;
        carry_we = 1'b0;
        st_we    = 1'b0;
        nd_d     = 1'b0;
        nd_we    = 1'b0;
        case (op)
            OP_LOAD, OP_LOAD_TREG: begin
                acc_d  = opnd;
                acc_we = 1'b1;
            end
            OP_LOAD_LO: begin
                acc_d  = {{WORD_W{1'b0}}, mem};
                acc_we = 1'b1;
            end
            OP_LOAD_SHORT: begin
                acc_d  = {{(A_W-IMM8_W){1'b0}}, imm8};
                acc_we = 1'b1;
            end
            OP_AND: begin
                acc_d  = acc_q & opnd;
                acc_we = 1'b1;
            end
            OP_OR: begin
                acc_d  = acc_q | opnd;
                acc_we = 1'b1;
            end
            OP_CMPL: begin
                acc_d  = ~acc_q;
                acc_we = 1'b1;
            end
            OP_NEG: begin
                acc_d  = {A_W{1'b0}} - acc_q;
                acc_we = 1'b1;
            end
            OP_SHL: begin
                acc_d    = {acc_q[MSB-1:0], 1'b0};
                carry_d  = acc_q[MSB];
                acc_we   = 1'b1;
                carry_we = 1'b1;
            end
            OP_SHR: begin
                acc_d    = {acc_q[MSB], acc_q[MSB:1]};
                carry_d  = acc_q[0];
                acc_we   = 1'b1;
                carry_we = 1'b1;
            end
            OP_ROTL: begin
                acc_d    = {acc_q[MSB-1:0], carry_q};
                carry_d  = acc_q[MSB];
                acc_we   = 1'b1;
                carry_we = 1'b1;
            end
            OP_ROTR: begin
                acc_d    = {carry_q, acc_q[MSB:1]};
                carry_d  = acc_q[0];
                acc_we   = 1'b1;
                carry_we = 1'b1;
            end
            OP_STORE_HI, OP_STORE_LO: begin
                st_we = 1'b1;
            end
            OP_NORM: begin
                nd_we = 1'b1;
                if ((acc_q != {A_W{1'b0}}) && (acc_q[MSB] == acc_q[MSB-1])) begin
                    acc_d  = {acc_q[MSB-1:0], 1'b0};
                    acc_we = 1'b1;
                    nd_d   = 1'b0;
                end else begin
                    nd_d   = 1'b1;
                end
            end
            default: begin
                acc_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_exec.sv
// Accumulator execute slice: decodes a presented word, sequences two-word
// long-immediate forms over two cycles and holds the architectural state.
// Assumes the memory operand is valid with the instruction word and that
// the immediate word is valid in the cycle where busy is high.
module acc_exec
    import acc_pkg::*;
#(
    parameter int WORD_W  = INSN_W,
    parameter int TREG_W  = 4,
    localparam int A_W    = 2 * WORD_W,
    localparam int SH_W   = SHAMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] imm_word,
    input  logic [WORD_W-1:0] mem_data,
    input  logic [TREG_W-1:0] treg_cnt,
    output logic [A_W-1:0]    acc,
    output logic              carry,
    output logic [WORD_W-1:0] store_data,
    output logic              store_valid,
    output logic              busy,
    output logic              norm_done
);

    acc_dec_t          dec_now;
    acc_dec_t          pend_q;
    acc_dec_t          exec_d;
    logic              fire;
    logic              take_first;
    logic [WORD_W-1:0] src;
    logic              sext;
    logic [A_W-1:0]    base;
    logic [SH_W-1:0]   amt;
    logic [A_W-1:0]    opnd;

    logic [A_W-1:0]    acc_q;
    logic              carry_q;
    logic [WORD_W-1:0] st_q;
    logic              stv_q;
    logic              busy_q;
    logic              nd_q;

    logic [A_W-1:0]    acc_d;
    logic              acc_we;
    logic              carry_d;
    logic              carry_we;
    logic [WORD_W-1:0] st_d;
    logic              st_we;
    logic              nd_d;
    logic              nd_we;

    acc_decode u_dec (
        .instr (instr),
        .dec   (dec_now)
    );

    // Choose what executes this cycle: a pending long form or the new word
    always_comb begin
        take_first = instr_valid && !busy_q && dec_now.two_word;
        fire       = busy_q || (instr_valid && !dec_now.two_word);
        exec_d     = busy_q ? pend_q : dec_now;
    end

    // Build the extended operand and its shift count
    always_comb begin
        src  = exec_d.two_word ? imm_word : mem_data;
        sext = (exec_d.op == OP_LOAD) || (exec_d.op == OP_LOAD_TREG);
        base = {{WORD_W{sext & src[WORD_W-1]}}, src};
        amt  = (exec_d.op == OP_LOAD_TREG)
             ? {{(SH_W-TREG_W){1'b0}}, treg_cnt}
             : exec_d.shamt;
    end

    acc_lshift #(.W(A_W), .SH_W(SH_W)) u_op_sh (
        .din  (base),
        .amt  (amt),
        .dout (opnd)
    );

    acc_alu #(.WORD_W(WORD_W), .SST_W(STSH_W)) u_alu (
        .op       (exec_d.op),
        .st_shamt (exec_d.shamt[STSH_W-1:0]),
        .imm8     (exec_d.imm8),
        .mem      (mem_data),
        .opnd     (opnd),
        .acc_q    (acc_q),
        .carry_q  (carry_q),
        .acc_d    (acc_d),
        .acc_we   (acc_we),
        .carry_d  (carry_d),
        .carry_we (carry_we),
        .st_d     (st_d),
        .st_we    (st_we),
        .nd_d     (nd_d),
        .nd_we    (nd_we)
    );

    // Two-word sequencing: latch the first word and flag the wait cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= '0;
        end else begin
            busy_q <= take_first;
            if (take_first) begin
                pend_q <= dec_now;
            end
        end
    end

    // Architectural state update, gated by the fire strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            st_q    <= '0;
            stv_q   <= 1'b0;
            nd_q    <= 1'b0;
        end else begin
            stv_q <= fire && st_we;
            if (fire && acc_we) begin
                acc_q <= acc_d;
            end
            if (fire && carry_we) begin
                carry_q <= carry_d;
            end
            if (fire && st_we) begin
                st_q <= st_d;
            end
            if (fire && nd_we) begin
                nd_q <= nd_d;
            end
        end
    end

    // Drive the outputs from state
    always_comb begin
        acc         = acc_q;
        carry       = carry_q;
        store_data  = st_q;
        store_valid = stv_q;
        busy        = busy_q;
        norm_done   = nd_q;
    end

endmodule

// File: rtl/acc_exec_chk.sv
// Protocol checker for acc_exec, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset.
module acc_exec_chk #(
    parameter int WORD_W = 16,
    parameter int TREG_W = 4,
    localparam int A_W   = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr,
    input logic [A_W-1:0]    acc,
    input logic              carry,
    input logic              store_valid,
    input logic              busy
);

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy) else $error("busy held past one cycle"); // R6

    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($past(instr_valid) && !$past(busy))) else $error("busy without first word"); // R6

    AST_FIRST_WORD_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(acc) && $stable(carry))) else $error("first word altered state"); // R6

    AST_STORE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid |-> ($stable(acc) && $stable(carry) && !busy)) else $error("store altered state"); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(instr_valid) && !$past(busy)) |-> ($stable(acc) && $stable(carry) && !store_valid))
        else $error("idle cycle changed state"); // R13

    AST_CARRY_ONLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> ($past(instr_valid) && !$past(busy))) else $error("carry moved without instruction"); // R14

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !$past(rst_n) |-> (acc == '0 && !carry && !busy && !store_valid)) else $error("reset state wrong"); // R1

    logic unused_ok;
    assign unused_ok = ^instr ^ ^TREG_W;

endmodule

bind acc_exec acc_exec_chk #(.WORD_W(WORD_W), .TREG_W(TREG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .acc         (acc),
    .carry       (carry),
    .store_valid (store_valid),
    .busy        (busy)
);

// File: tb/tb_acc_exec.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks compute expected results from a model
// of the requirements and queue them; a monitor compares at each due cycle.
module tb_acc_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] imm_word = '0;
    logic [15:0] mem_data = '0;
    logic [3:0]  treg_cnt = '0;
    logic [31:0] acc;
    logic        carry;
    logic [15:0] store_data;
    logic        store_valid;
    logic        busy;
    logic        norm_done;

    acc_exec dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .imm_word    (imm_word),
        .mem_data    (mem_data),
        .treg_cnt    (treg_cnt),
        .acc         (acc),
        .carry       (carry),
        .store_data  (store_data),
        .store_valid (store_valid),
        .busy        (busy),
        .norm_done   (norm_done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [31:0] acc;
        logic        c;
        logic        sv;
        logic [15:0] sd;
        logic        nd;
        logic        bz;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_fail = 0;
    logic bad;

    logic [31:0] m_acc = '0;
    logic        m_c = 1'b0;
    logic        m_nd = 1'b0;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic expect_next(input logic [31:0] a, input logic c, input logic sv,
                               input logic [15:0] sd, input logic nd, input logic bz,
                               input string tag);
        exp_t e;
        e.due = cyc + 1; e.acc = a; e.c = c; e.sv = sv; e.sd = sd;
        e.nd = nd; e.bz = bz; e.tag = tag;
        q.push_back(e);
    endtask

    // Single-word instruction: result visible one edge later
    task automatic one(input logic [15:0] w, input logic [15:0] m, input logic [31:0] ea,
                       input logic ec, input logic esv, input logic [15:0] esd,
                       input logic e_nd, input string tag);
        instr = w; instr_valid = 1'b1; mem_data = m;
        expect_next(ea, ec, esv, esd, e_nd, 1'b0, tag);
        m_acc = ea; m_c = ec; m_nd = e_nd;
        @(negedge clk);
    endtask

    // Two-word instruction: busy cycle, then result; a stray complement
    // word is presented during the busy cycle and must be ignored
    task automatic two(input logic [15:0] w, input logic [15:0] imm,
                       input logic [31:0] ea, input string tag);
        instr = w; instr_valid = 1'b1; mem_data = 16'h5A5A;
        expect_next(m_acc, m_c, 1'b0, 16'h0, m_nd, 1'b1, tag);
        @(negedge clk);
        instr = 16'hBE01; instr_valid = 1'b1; imm_word = imm;
        expect_next(ea, m_c, 1'b0, 16'h0, m_nd, 1'b0, tag);
        m_acc = ea;
        @(negedge clk);
        imm_word = 16'hDEAD;
    endtask

    task automatic idle(input string tag);
        instr_valid = 1'b0; instr = 16'hBE01;
        expect_next(m_acc, m_c, 1'b0, 16'h0, m_nd, 1'b0, tag);
        @(negedge clk);
    endtask

    task automatic lacc_m(input logic [3:0] sh, input logic [15:0] m);
        one({4'b0001, sh, 8'h23}, m, sx(m) << sh, m_c, 1'b0, 16'h0, m_nd, "R2");
    endtask

    task automatic lacc_hi(input logic [15:0] m);
        one(16'h6A11, m, {m, 16'h0000}, m_c, 1'b0, 16'h0, m_nd, "R2");
    endtask

    task automatic lacl_m(input logic [15:0] m);
        one(16'h6987, m, {16'h0000, m}, m_c, 1'b0, 16'h0, m_nd, "R3");
    endtask

    task automatic lacl_s(input logic [7:0] b);
        one({8'hB9, b}, 16'hFFFF, {24'h0, b}, m_c, 1'b0, 16'h0, m_nd, "R3");
    endtask

    task automatic lact(input logic [3:0] t, input logic [15:0] m);
        treg_cnt = t;
        one(16'h6B05, m, sx(m) << t, m_c, 1'b0, 16'h0, m_nd, "R4");
    endtask

    task automatic and_m(input logic [15:0] m);
        one(16'h6E44, m, m_acc & {16'h0000, m}, m_c, 1'b0, 16'h0, m_nd, "R5");
    endtask

    task automatic or_m(input logic [15:0] m);
        one(16'h6D44, m, m_acc | {16'h0000, m}, m_c, 1'b0, 16'h0, m_nd, "R5");
    endtask

    // kind 0 AND, 1 OR, 2 load; sh in 0..16
    task automatic lng(input int kind, input int sh, input logic [15:0] imm);
        logic [15:0] w;
        logic [31:0] o;
        logic [31:0] e;
        o = {16'h0000, imm} << sh;
        if (kind == 0) begin
            w = (sh == 16) ? 16'hBE81 : {12'hBFB, sh[3:0]};
            e = m_acc & o;
        end else if (kind == 1) begin
            w = (sh == 16) ? 16'hBE82 : {12'hBFC, sh[3:0]};
            e = m_acc | o;
        end else begin
            w = {12'hBF8, sh[3:0]};
            e = sx(imm) << sh;
        end
        two(w, imm, e, "R6 R7");
    endtask

    task automatic store(input logic hi, input logic [2:0] sh);
        logic [31:0] t;
        t = m_acc << sh;
        one({4'b1001, hi, sh, 8'h40}, 16'h0, m_acc, m_c, 1'b1,
            hi ? t[31:16] : t[15:0], m_nd, "R11");
    endtask

    task automatic norm();
        if (m_acc != 32'h0 && m_acc[31] == m_acc[30])
            one(16'hA0F0, 16'h0, m_acc << 1, m_c, 1'b0, 16'h0, 1'b0, "R12");
        else
            one(16'hA0F0, 16'h0, m_acc, m_c, 1'b0, 16'h0, 1'b1, "R12");
    endtask

    task automatic bad_word(input logic [15:0] w);
        one(w, 16'h1357, m_acc, m_c, 1'b0, 16'h0, m_nd, "R13");
    endtask

    // Monitor: compare the head of the queue when its cycle arrives
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            cur = q.pop_front();
            bad = (acc !== cur.acc) || (carry !== cur.c) || (store_valid !== cur.sv) ||
                  (norm_done !== cur.nd) || (busy !== cur.bz) ||
                  (cur.sv && (store_data !== cur.sd));
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got acc=%h c=%b sv=%b sd=%h nd=%b busy=%b, expected acc=%h c=%b sv=%b sd=%h nd=%b busy=%b",
                         cur.tag, cyc, acc, carry, store_valid, store_data, norm_done, busy,
                         cur.acc, cur.c, cur.sv, cur.sd, cur.nd, cur.bz);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        expect_next(32'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        lacc_m(4'd4, 16'h8001);
        lacc_m(4'd15, 16'h7FFF);
        lacc_hi(16'h1234);
        lacl_m(16'hBEEF);
        lacl_s(8'hA5);
        lact(4'd3, 16'hFFFE);
        lact(4'd15, 16'h0001);
        or_m(16'h0F0F);
        and_m(16'h00FF);

        lng(2, 8, 16'h8234);
        lng(0, 4, 16'h0FF0);
        lng(1, 16, 16'h00C3);
        lng(0, 16, 16'hFFFF);
        lng(2, 0, 16'h7FFF);
        lng(1, 15, 16'h0003);

        one(16'hBE01, 16'h0, ~m_acc, m_c, 1'b0, 16'h0, m_nd, "R8");
        one(16'hBE02, 16'h0, 32'h0 - m_acc, m_c, 1'b0, 16'h0, m_nd, "R8");

        one(16'hBE09, 16'h0, m_acc << 1, m_acc[31], 1'b0, 16'h0, m_nd, "R9");
        lacc_hi(16'h8000);
        or_m(16'h0001);
        one(16'hBE0A, 16'h0, $signed(m_acc) >>> 1, m_acc[0], 1'b0, 16'h0, m_nd, "R9");
        one(16'hBE01, 16'h0, ~m_acc, m_c, 1'b0, 16'h0, m_nd, "R14");
        lng(1, 0, 16'h1111);
        one(16'hBE01, 16'h0, ~m_acc, m_c, 1'b0, 16'h0, m_nd, "R14");

        lacc_hi(16'hC000);
        one(16'hBE0C, 16'h0, {m_acc[30:0], m_c}, m_acc[31], 1'b0, 16'h0, m_nd, "R10");
        one(16'hBE0D, 16'h0, {m_c, m_acc[31:1]}, m_acc[0], 1'b0, 16'h0, m_nd, "R10");
        one(16'hBE0D, 16'h0, {m_c, m_acc[31:1]}, m_acc[0], 1'b0, 16'h0, m_nd, "R10");
        one(16'hBE0C, 16'h0, {m_acc[30:0], m_c}, m_acc[31], 1'b0, 16'h0, m_nd, "R10");

        lacc_hi(16'h5678);
        or_m(16'h9ABC);
        store(1'b1, 3'd4);
        store(1'b0, 3'd3);
        store(1'b1, 3'd0);
        store(1'b0, 3'd7);
        idle("R11");
        idle("R13");

        norm();
        lacl_s(8'h01);
        norm();
        norm();
        norm();
        lacc_m(4'd0, 16'h0000);
        norm();
        one(16'hBE02, 16'h0, 32'h0, m_c, 1'b0, 16'h0, m_nd, "R8");
        lacc_m(4'd0, 16'hF000);
        norm();
        norm();
        lacc_m(4'd0, 16'h8000);
        norm();

        bad_word(16'hBE00);
        bad_word(16'h0000);
        bad_word(16'hBF20);
        bad_word(16'hFFFF);
        idle("R13");
        idle("R13");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R13: %0d expected results never compared, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule